// File: doc/BRIEF.md
# Direct-Mapped Read-Only Load Cache

This block sits between a processor's byte-load port and a slower backing memory. It stores a set of equally sized blocks, and each block has exactly one possible home line. The home line is chosen by a field of the byte address. A load that finds its block already resident returns the addressed byte one cycle after it is accepted.

A load whose block is absent stalls the requester. The block then fetches the whole aligned block from the backing memory in a single wide transfer, overwrites the home line and returns the byte. There is no replacement choice: whatever the home line held is discarded, even valid data, so two blocks that share an index keep evicting each other. The number of lines and the block size are parameters. Writes are not handled.

Top module: `dm_load_cache`

## Requirements
- R1: After reset every line is invalid, so the first load to any line is a miss. While reset is held and afterwards with no request, `ld_valid_o`, `hit_o`, `miss_o`, `mem_req_o` and `ld_stall_o` are all low.
- R2: The byte address is split into three fields. The low log2(BLOCK_BYTES) bits are the byte offset, the next log2(LINES) bits are the line index, and the remaining upper bits are the tag.
- R3: A load hits only when the indexed line is valid and its stored tag equals the address tag. The cycle after acceptance carries `ld_valid_o` and `hit_o`, and `ld_data_o` holds byte k of the block, where byte k is stored at block bits [8k+7:8k] and k is the offset.
- R4: A missing load raises `ld_stall_o` in the cycle it is presented. From the next cycle `mem_req_o` is high, and `mem_addr_o` equals the load address with its offset bits cleared.
- R5: `ld_stall_o` stays high for the whole refill and falls only in the cycle where `mem_ready_i` is high; the requester holds `ld_req_i` and `ld_addr_i` steady while stalled. The next cycle carries `ld_valid_o`, `miss_o` and the addressed byte taken from `mem_block_i`.
- R6: A refill overwrites the indexed line with the new tag and block regardless of what it held, so a later load of the evicted block misses again.
- R7: Every completed load gives exactly one pulse, on `hit_o` or on `miss_o`, in the same cycle as `ld_valid_o`. Neither pulses without `ld_valid_o`.
- R8: Any number of wait cycles before `mem_ready_i` is tolerated. During the wait, `mem_req_o` and `mem_addr_o` hold steady.
- R9: With a 5-bit address, 4 lines and 2-byte blocks, loads from addresses 1, 5, 1, 4, 0, 12, 8, 4, 0, 12, 8 after reset give miss, miss, hit, hit, hit, then six misses: 3 hits and 8 misses in total.
- R10: A hit never raises `mem_req_o`, and `mem_req_o` is low whenever no refill is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_req_i | input | 1 | Load request |
| ld_addr_i | input | ADDR_W | Byte address of the load |
| ld_stall_o | output | 1 | Request not accepted this cycle; hold it |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 8 | Loaded byte |
| hit_o | output | 1 | Completed load was a hit |
| miss_o | output | 1 | Completed load was a miss |
| mem_req_o | output | 1 | Block refill request |
| mem_addr_o | output | ADDR_W | Block-aligned refill address |
| mem_ready_i | input | 1 | Refill data present this cycle |
| mem_block_i | input | 8*BLOCK_BYTES | Whole refill block, byte k at bits [8k+7:8k] |

## Verification
The assertions assume that the requester keeps `ld_req_i` high and `ld_addr_i` unchanged in every cycle after one in which `ld_stall_o` was high. They also assume that the memory returns data only while `mem_req_o` is high. The stimulus meets both conditions because each load is issued by one task, which holds the request until it sees the stall low just before a clock edge. The memory model raises ready only in response to a pending refill, after a wait it draws at random or forces to a long fixed value.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic [0:0] {
    ST_LOOKUP = 1'b0,
    ST_FILL   = 1'b1
  } dlc_state_e;
endpackage

// File: rtl/dlc_split.sv
module dlc_split #(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 1,
  parameter int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [OFF_W-1:0]  off_o
);
  assign off_o = addr_i[OFF_W-1:0];
  assign idx_o = addr_i[OFF_W +: IDX_W];
  assign tag_o = addr_i[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/dlc_store.sv
module dlc_store #(
  parameter int LINES = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 2,
  parameter int BLK_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [BLK_W-1:0] rd_blk_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [BLK_W-1:0] wr_blk_i
);
  logic             valid_q [LINES];
  logic [TAG_W-1:0] tag_q   [LINES];
  logic [BLK_W-1:0] blk_q   [LINES];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(l));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  valid_q[l] <= 1'b0;
      else if (sel) valid_q[l] <= 1'b1;
    end

    // payload needs no reset; valid bit guards it
    always_ff @(posedge clk_i) begin
      if (sel) begin
        tag_q[l] <= wr_tag_i;
        blk_q[l] <= wr_blk_i;
      end
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_blk_o   = blk_q[rd_idx_i];
endmodule

// File: rtl/dlc_bytesel.sv
module dlc_bytesel #(
  parameter int BLOCK_BYTES = 2,
  parameter int OFF_W       = 1
) (
  input  logic [8*BLOCK_BYTES-1:0] blk_i,
  input  logic [OFF_W-1:0]         off_i,
  output logic [7:0]               byte_o
);
  logic [7:0] lane [BLOCK_BYTES];

  for (genvar k = 0; k < BLOCK_BYTES; k++) begin : g_lane
    assign lane[k] = blk_i[8*k +: 8];
  end

  assign byte_o = lane[off_i];
endmodule

// File: rtl/dlc_ctrl.sv
module dlc_ctrl
  import dlc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic hit_i,
  input  logic mem_ready_i,
  output logic stall_o,
  output logic mem_req_o,
  output logic fill_o,
  output logic accept_o,
  output logic filling_o
);
  dlc_state_e state_q, state_d;

  assign filling_o = (state_q == ST_FILL);
  assign mem_req_o = filling_o;
  assign fill_o    = filling_o && mem_ready_i;
  // stall drops in the refill's last cycle so the held request retires there
  assign stall_o   = filling_o ? !mem_ready_i : (req_i && !hit_i);
  assign accept_o  = req_i && !stall_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOOKUP: if (req_i && !hit_i) state_d = ST_FILL;
      ST_FILL:   if (mem_ready_i)     state_d = ST_LOOKUP;
      default:                        state_d = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOOKUP;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/dm_load_cache.sv
module dm_load_cache #(
  parameter int ADDR_W      = 5,
  parameter int LINES       = 4,
  parameter int BLOCK_BYTES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ld_req_i,
  input  logic [ADDR_W-1:0]        ld_addr_i,
  output logic                     ld_stall_o,
  output logic                     ld_valid_o,
  output logic [7:0]               ld_data_o,
  output logic                     hit_o,
  output logic                     miss_o,
  output logic                     mem_req_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  input  logic                     mem_ready_i,
  input  logic [8*BLOCK_BYTES-1:0] mem_block_i
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int BLK_W = 8 * BLOCK_BYTES;

  logic [TAG_W-1:0] a_tag, l_tag;
  logic [IDX_W-1:0] a_idx;
  logic [OFF_W-1:0] a_off;
  logic             l_valid, hit;
  logic [BLK_W-1:0] l_blk, src_blk;
  logic [7:0]       sel_byte;
  logic             stall, fill, accept, filling;

  dlc_split #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
  ) u_split (
    .addr_i(ld_addr_i), .tag_o(a_tag), .idx_o(a_idx), .off_o(a_off)
  );

  dlc_store #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_idx_i(a_idx), .rd_valid_o(l_valid), .rd_tag_o(l_tag), .rd_blk_o(l_blk),
    .wr_en_i(fill), .wr_idx_i(a_idx), .wr_tag_i(a_tag), .wr_blk_i(mem_block_i)
  );

  assign hit = l_valid && (l_tag == a_tag);

  dlc_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(ld_req_i), .hit_i(hit), .mem_ready_i(mem_ready_i),
    .stall_o(stall), .mem_req_o(mem_req_o), .fill_o(fill),
    .accept_o(accept), .filling_o(filling)
  );

  // a refill forwards the incoming block, bypassing the array
  assign src_blk = filling ? mem_block_i : l_blk;

  dlc_bytesel #(
    .BLOCK_BYTES(BLOCK_BYTES), .OFF_W(OFF_W)
  ) u_bytesel (
    .blk_i(src_blk), .off_i(a_off), .byte_o(sel_byte)
  );

  logic       valid_q, hit_q, miss_q;
  logic [7:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      miss_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= accept;
      hit_q   <= accept && !filling;
      miss_q  <= accept && filling;
      if (accept) data_q <= sel_byte;
    end
  end

  assign ld_stall_o = stall;
  assign ld_valid_o = valid_q;
  assign ld_data_o  = data_q;
  assign hit_o      = hit_q;
  assign miss_o     = miss_q;
  assign mem_addr_o = {a_tag, a_idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/dm_load_cache_checker.sv
module dm_load_cache_checker #(
  parameter int ADDR_W = 5,
  parameter int OFF_W  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ld_req_i,
  input logic [ADDR_W-1:0] ld_addr_i,
  input logic              ld_stall_o,
  input logic              ld_valid_o,
  input logic              hit_o,
  input logic              miss_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ready_i
);
  p_hold_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_stall_o |=> ld_req_i && $stable(ld_addr_i));

  p_stall_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |-> ld_stall_o);

  p_fill_resp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i |=> ld_valid_o && miss_o);

  p_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[OFF_W-1:0] == '0);

  p_miss_starts_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_req_i && ld_stall_o && !mem_req_o |=> mem_req_o);

  p_one_event_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> $onehot({hit_o, miss_o}));

  p_no_stray_event_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_o |-> !hit_o && !miss_o);

  p_wait_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

  p_hit_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_req_i && !ld_stall_o && !mem_req_o |=> hit_o);
endmodule

bind dm_load_cache dm_load_cache_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ld_req_i(ld_req_i), .ld_addr_i(ld_addr_i),
  .ld_stall_o(ld_stall_o), .ld_valid_o(ld_valid_o), .hit_o(hit_o),
  .miss_o(miss_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_ready_i(mem_ready_i)
);

// File: tb/dm_load_cache_bench.sv
`timescale 1ns/1ps
module dm_load_cache_bench;
  localparam int ADDR_W = 5;
  localparam int LINES = 4;
  localparam int BLOCK_BYTES = 2;
  localparam int OFF_W = 1;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_req = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic ld_stall, ld_valid, hit, miss, mem_req, mem_ready = 1'b0;
  logic [7:0] ld_data;
  logic [ADDR_W-1:0] mem_addr;
  logic [8*BLOCK_BYTES-1:0] mem_block = '0;

  int n_checks = 0, n_fail = 0;
  int min_wait = 0, max_wait = 3;
  int wait_left = 0;
  bit in_fill = 0, fill_seen = 0;
  logic [ADDR_W-1:0] last_mem_addr = '0;
  bit m_valid [LINES];
  logic [ADDR_W-IDX_W-OFF_W-1:0] m_tag [LINES];
  int stall_cycles = 0;
  bit last_hit = 0;

  always #10 clk = ~clk;

  dm_load_cache u_dm_load_cache (
    .clk_i(clk), .rst_ni(rst_n), .ld_req_i(ld_req), .ld_addr_i(ld_addr),
    .ld_stall_o(ld_stall), .ld_valid_o(ld_valid), .ld_data_o(ld_data),
    .hit_o(hit), .miss_o(miss), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ready_i(mem_ready), .mem_block_i(mem_block)
  );

  function automatic logic [7:0] mem_byte(input int a);
    return 8'((a * 37 + 11) ^ (a >> 2));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // backing memory: answers a pending refill after a drawn wait
  always @(negedge clk) begin
    mem_ready = 1'b0;
    if (!rst_n) in_fill = 0;
    else if (mem_req) begin
      fill_seen = 1;
      if (!in_fill) begin
        in_fill = 1;
        wait_left = $urandom_range(max_wait, min_wait);
      end
      if (wait_left == 0) begin
        mem_ready = 1'b1;
        last_mem_addr = mem_addr;
        for (int k = 0; k < BLOCK_BYTES; k++)
          mem_block[8*k +: 8] = mem_byte(int'(mem_addr) + k);
        in_fill = 0;
      end else wait_left--;
    end
  end

  task automatic do_reset();
    ld_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int l = 0; l < LINES; l++) m_valid[l] = 0;
  endtask

  task automatic do_load(input logic [ADDR_W-1:0] a, input string req);
    int idx;
    logic [ADDR_W-IDX_W-OFF_W-1:0] tg;
    bit exp_hit, acc;
    idx = int'(a[OFF_W +: IDX_W]);
    tg = a[ADDR_W-1 -: (ADDR_W-IDX_W-OFF_W)];
    exp_hit = m_valid[idx] && (m_tag[idx] == tg);
    stall_cycles = 0;
    @(negedge clk);
    fill_seen = 0;
    ld_req = 1'b1;
    ld_addr = a;
    forever begin
      #2;
      acc = !ld_stall;
      @(posedge clk);
      if (acc) break;
      stall_cycles++;
      @(negedge clk);
    end
    @(negedge clk);
    ld_req = 1'b0;
    last_hit = hit;
    chk(ld_valid && (hit ^ miss), "R7", {ld_valid, hit, miss}, 1);
    chk(hit == exp_hit, {req, "/R3"}, hit, exp_hit);
    chk(ld_data == mem_byte(int'(a)), {req, "/R3"}, ld_data, mem_byte(int'(a)));
    if (exp_hit) chk(!fill_seen && stall_cycles == 0, "R10", fill_seen, 0);
    else begin
      chk(last_mem_addr == {a[ADDR_W-1:OFF_W], 1'b0}, "R4", last_mem_addr,
          {a[ADDR_W-1:OFF_W], 1'b0});
      chk(stall_cycles >= 1, "R5", stall_cycles, 1);
    end
    m_valid[idx] = 1;
    m_tag[idx] = tg;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int trace [11] = '{1, 5, 1, 4, 0, 12, 8, 4, 0, 12, 8};
    bit exp_h [11] = '{0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0};
    int n_hit, n_miss;
    void'($urandom(32'd2024));
    do_reset();
    #2;
    // R1: idle outputs after reset
    chk(!ld_valid && !hit && !miss && !mem_req && !ld_stall, "R1",
        {ld_valid, hit, miss, mem_req, ld_stall}, 0);

    // R9 reference trace
    n_hit = 0; n_miss = 0;
    for (int i = 0; i < 11; i++) begin
      do_load(5'(trace[i]), "R9");
      chk(last_hit == exp_h[i], "R9 pattern", last_hit, exp_h[i]);
      if (last_hit) n_hit++; else n_miss++;
    end
    chk(n_hit == 3, "R9 hits", n_hit, 3);
    chk(n_miss == 8, "R9 misses", n_miss, 8);

    // R6: conflicting blocks evict each other
    do_load(5'd6, "R6");
    do_load(5'd22, "R6");
    chk(!last_hit, "R6 evict", last_hit, 0);
    do_load(5'd7, "R6");
    chk(!last_hit, "R6 evicted block misses", last_hit, 0);
    // R2: same block other offset hits
    do_load(5'd6, "R2");
    chk(last_hit, "R2 same block", last_hit, 1);

    // R8: long refill wait
    min_wait = 15; max_wait = 15;
    do_load(5'd31, "R8");
    chk(stall_cycles >= 16, "R8 stall span", stall_cycles, 16);
    min_wait = 0; max_wait = 3;

    // R1: reset invalidates resident lines
    do_load(5'd30, "R1");
    chk(last_hit, "R1 resident", last_hit, 1);
    do_reset();
    do_load(5'd30, "R1");
    chk(!last_hit, "R1 cold after reset", last_hit, 0);

    // random loads, model-checked (R2, R3, R5, R6)
    for (int i = 0; i < 300; i++) begin
      max_wait = (i % 50 == 0) ? 8 : 3;
      do_load(5'($urandom_range(31, 0)), "R2");
    end

    repeat (3) @(negedge clk);
    #2;
    chk(!mem_req && !ld_valid, "R10 idle", mem_req, 0);
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule